// File: doc/BRIEF.md
# Bidirectional Shift and Rotate Unit

This unit moves a parameterised data word left or right by a signed count. It can run as a logical shift, an arithmetic shift or a rotate. Arithmetic shifts are symmetric. A right arithmetic shift copies the word's top bit into the vacated positions. A left arithmetic shift copies the word's bottom bit into the vacated positions. A negative count turns the operation around. For example, a left operation by -N gives exactly the same result as the right operation of the same kind by +N, and this includes which end supplies the fill bit.

A control stage looks at the sign of the count and negates the count when it is negative. It also derives the effective direction, the saturation case and the rotate amount taken modulo the width. It hands these to a datapath as a few strobes plus a stage amount. The datapath is a logarithmic shifter that works in one direction only: a left request reverses the word before the stages and reverses it again after them. An optional output register adds one cycle of latency. A build option drops the sign handling: the count is then read as unsigned and only the direction input decides the direction.

Top module: `shift_rotate_unit`

## Requirements
- R1: With `mode` = 2'b00 (logical), the vacated positions are filled with zeros in both directions (`dirLeft` = 1 means left, 0 means right).
- R2: With `mode` = 2'b01 (arithmetic) and an effective right direction, the vacated high positions take the original bit WIDTH-1.
- R3: With `mode` = 2'b01 and an effective left direction, the vacated low positions take the original bit 0, so bit 0 keeps its value.
- R4: With `mode` = 2'b10 or 2'b11 (rotate), bits leaving one end re-enter at the other, in both directions. A left rotate followed by a right rotate by the same count restores the word.
- R5: `shiftCnt` is two's complement, CNT_W = clog2(WIDTH)+2 bits wide. A count of -N gives the same result as the same mode in the opposite direction by +N, with the fill bit taken from the end that matches the effective direction.
- R6: For shifts, a count magnitude of WIDTH or more gives a word made entirely of the fill bit. For rotates, the magnitude is taken modulo WIDTH.
- R7: A count of zero passes `dataIn` through unchanged in every mode and in both directions.
- R8: With REG_OUT = 1, `dataOut` reflects the inputs one clock edge later, holds its value between edges, and reads zero while `rstN` is low. With REG_OUT = 0, `dataOut` is combinational.
- R9: With DIR_ONLY = 1, `shiftCnt` is read as unsigned (0 to 2^CNT_W-1) and `dirLeft` alone selects the direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low asynchronous reset |
| dataIn | input | WIDTH | Word to be shifted or rotated |
| shiftCnt | input | CNT_W | Shift count: two's complement, or unsigned when DIR_ONLY = 1 |
| dirLeft | input | 1 | 1 = left, 0 = right, before any reversal by the count's sign |
| mode | input | 2 | 00 logical, 01 arithmetic, 1x rotate |
| dataOut | output | WIDTH | Result, registered when REG_OUT = 1 |

## Verification
The two functions that meet in one cycle are the sign-driven reversal of direction and the choice of fill bit. A negative arithmetic count has to flip the direction and also move the fill source to the other end of the word. The bench provokes this by sweeping every count from -WIDTH-1 to WIDTH+1 in both directions and all modes. The data words include ones whose top and bottom bits differ, so a wrong fill end shows up in the result. Each result is compared with a bit-indexed model that flips the direction first and then picks the fill bit.

// File: rtl/shift_rotate_pkg.sv
package shift_rotate_pkg;

  typedef enum logic [1:0] {
    MODE_LOGIC = 2'b00,
    MODE_ARITH = 2'b01,
    MODE_ROT   = 2'b10,
    MODE_ROT_B = 2'b11
  } shiftMode_e;

  typedef struct packed {
    logic effLeft;
    logic isRotate;
    logic isArith;
    logic saturate;
  } shiftStrobes_t;

endpackage

// File: rtl/shift_rotate_ctrl.sv
module shift_rotate_ctrl
  import shift_rotate_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit DIR_ONLY = 1'b0,
  localparam int CNT_W   = $clog2(WIDTH) + 2,
  localparam int SH_W    = $clog2(WIDTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    shiftCnt,
  input  logic                dirLeft,
  input  logic [1:0]          mode,
  output shiftStrobes_t       strobes,
  output logic [SH_W-1:0]     amount
);

  logic             cntNeg;
  logic [CNT_W-1:0] mag;
  logic [CNT_W-1:0] magMod;

  generate
    if (DIR_ONLY) begin : g_unsigned
      assign cntNeg = 1'b0;
      assign mag    = shiftCnt;
    end else begin : g_signed
      assign cntNeg = shiftCnt[CNT_W-1];
      assign mag    = cntNeg ? (~shiftCnt + CNT_W'(1)) : shiftCnt;
    end
  endgenerate

  assign magMod = mag % CNT_W'(WIDTH);
  assign amount = magMod[SH_W-1:0];

  always_comb begin
    strobes.effLeft  = dirLeft ^ cntNeg;
    strobes.isRotate = mode[1];
    strobes.isArith  = (mode == MODE_ARITH);
    strobes.saturate = !mode[1] && (mag >= CNT_W'(WIDTH));
  end

  // R6: the stage amount never reaches the word width
  assert_amount_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(amount) < WIDTH);

endmodule

// File: rtl/shift_rotate_dpath.sv
module shift_rotate_dpath
  import shift_rotate_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int SH_W   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dataIn,
  input  shiftStrobes_t    strobes,
  input  logic [SH_W-1:0]  amount,
  output logic [WIDTH-1:0] dataOut
);

  logic [WIDTH-1:0] revIn;
  logic [WIDTH-1:0] stg [0:SH_W];
  logic [WIDTH-1:0] rightRes;
  logic [WIDTH-1:0] result;
  logic             fillBit;

  // reverse on the way in so every stage only moves rightwards
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev_in
    assign revIn[i] = strobes.effLeft ? dataIn[WIDTH-1-i] : dataIn[i];
  end

  assign fillBit = strobes.isArith & revIn[WIDTH-1];
  assign stg[0]  = revIn;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = !amount[k]      ? stg[k] :
                      strobes.isRotate ? {stg[k][S-1:0], stg[k][WIDTH-1:S]} :
                                         {{S{fillBit}}, stg[k][WIDTH-1:S]};
  end

  assign rightRes = strobes.saturate ? {WIDTH{fillBit}} : stg[SH_W];

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev_out
    assign result[i] = strobes.effLeft ? rightRes[WIDTH-1-i] : rightRes[i];
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) dataOut <= '0;
        else       dataOut <= result;
      end
    end else begin : g_comb
      assign dataOut = result;
    end
  endgenerate

  // R4: a rotate neither creates nor loses set bits
  assert_rotate_keeps_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.isRotate |-> $countones(result) == $countones(dataIn));

  // R1: a logical shift never adds set bits
  assert_logical_no_new_ones_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.isRotate && !strobes.isArith) |-> $countones(result) <= $countones(dataIn));

  // R7: a zero amount without saturation is a pass-through
  assert_zero_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (amount == '0 && !strobes.saturate) |-> result == dataIn);

  // R6: a saturated shift is a uniform word
  assert_saturate_uniform_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.saturate |-> (result == '0 || result == '1));

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shift_rotate_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit DIR_ONLY = 1'b0,
  parameter bit REG_OUT  = 1'b1,
  localparam int CNT_W   = $clog2(WIDTH) + 2,
  localparam int SH_W    = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [CNT_W-1:0] shiftCnt,
  input  logic             dirLeft,
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] dataOut
);

  shiftStrobes_t   strobes;
  logic [SH_W-1:0] amount;

  shift_rotate_ctrl #(.WIDTH(WIDTH), .DIR_ONLY(DIR_ONLY)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .shiftCnt(shiftCnt),
    .dirLeft (dirLeft),
    .mode    (mode),
    .strobes (strobes),
    .amount  (amount)
  );

  shift_rotate_dpath #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .dataIn (dataIn),
    .strobes(strobes),
    .amount (amount),
    .dataOut(dataOut)
  );

endmodule

// File: tb/shift_rotate_unit_bench.sv
`timescale 1ns/1ps
module shift_rotate_unit_bench;

  localparam int W  = 8;
  localparam int CW = $clog2(W) + 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [W-1:0]  dataIn = '0;
  logic [CW-1:0] shiftCnt = '0;
  logic          dirLeft = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [W-1:0]  dataOut;
  logic [W-1:0]  dataOutUns;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shift_rotate_unit #(.WIDTH(W), .DIR_ONLY(1'b0), .REG_OUT(1'b1)) u_shift_rotate_unit (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .shiftCnt(shiftCnt),
    .dirLeft(dirLeft), .mode(mode), .dataOut(dataOut)
  );

  shift_rotate_unit #(.WIDTH(W), .DIR_ONLY(1'b1), .REG_OUT(1'b0)) u_shift_rotate_unit_uns (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .shiftCnt(shiftCnt),
    .dirLeft(dirLeft), .mode(mode), .dataOut(dataOutUns)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] d, int n, bit left, logic [1:0] md);
    logic [W-1:0] o;
    bit lft = left;
    int m = n;
    logic fill;
    if (m < 0) begin m = -m; lft = !lft; end
    if (md[1]) begin
      m = m % W;
      for (int i = 0; i < W; i++)
        o[i] = lft ? d[(i - m + W) % W] : d[(i + m) % W];
    end else begin
      fill = (md == 2'b01) ? (lft ? d[0] : d[W-1]) : 1'b0;
      for (int i = 0; i < W; i++) begin
        if (lft) o[i] = (i - m >= 0) ? d[i-m] : fill;
        else     o[i] = (i + m < W)  ? d[i+m] : fill;
      end
    end
    return o;
  endfunction

  function automatic string tagFor(int n, bit left, logic [1:0] md);
    if (n < 0) return "R5";
    if (n == 0) return "R7";
    if (!md[1] && n >= W) return "R6";
    if (md[1]) return "R4";
    if (md == 2'b01) return left ? "R3" : "R2";
    return "R1";
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cnt=%0d left=%0b mode=%0d data=%h)",
               tag, act, exp, $signed(shiftCnt), dirLeft, mode, dataIn);
    end
  endtask

  task automatic drive(logic [W-1:0] d, int n, bit left, logic [1:0] md);
    @(negedge clk);
    dataIn   = d;
    shiftCnt = CW'(n);
    dirLeft  = left;
    mode     = md;
  endtask

  initial begin
    logic [W-1:0] d;
    logic [W-1:0] rotOut;
    logic [W-1:0] prevExp;
    // R8: reset holds the registered output at zero
    dataIn = 8'hA5; shiftCnt = CW'(1); dirLeft = 1'b1; mode = 2'b00;
    repeat (3) @(negedge clk);
    check("R8", dataOut, '0);
    rstN = 1'b1;

    // signed sweep: every mode, both directions, counts -W-1..W+1
    for (int md = 0; md < 4; md++)
      for (int lf = 0; lf < 2; lf++)
        for (int n = -W-1; n <= W+1; n++)
          for (int rep = 0; rep < 6; rep++) begin
            d = (rep == 0) ? 8'h80 : (rep == 1) ? 8'h01 : (rep == 2) ? 8'hC3 : W'($urandom);
            drive(d, n, lf[0], md[1:0]);
            @(negedge clk);
            check(tagFor(n, lf[0], md[1:0]), dataOut, model(d, n, lf[0], md[1:0]));
          end

    // R9: unsigned-count build, full unsigned range, combinational output
    for (int md = 0; md < 4; md++)
      for (int lf = 0; lf < 2; lf++)
        for (int n = 0; n < (1 << CW); n++) begin
          d = (n % 2 == 0) ? 8'h81 : W'($urandom);
          drive(d, n, lf[0], md[1:0]);
          #1;
          check("R9", dataOutUns, model(d, n, lf[0], md[1:0]));
        end

    // R4: left rotate then right rotate by the same count restores the word
    for (int n = 0; n <= W + 1; n++) begin
      d = W'($urandom);
      drive(d, n, 1'b1, 2'b10);
      @(negedge clk);
      rotOut = dataOut;
      drive(rotOut, n, 1'b0, 2'b11);
      @(negedge clk);
      check("R4", dataOut, d);
    end

    // R8: one edge of latency, held between edges
    drive(8'h3C, 2, 1'b1, 2'b00);
    @(negedge clk);
    prevExp = model(8'h3C, 2, 1'b1, 2'b00);
    check("R8", dataOut, prevExp);
    drive(8'h96, -3, 1'b1, 2'b01);
    #1;
    check("R8", dataOut, prevExp);
    @(negedge clk);
    check("R8", dataOut, model(8'h96, -3, 1'b1, 2'b01));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule